// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port. Software programs it through a small word-addressed register interface with a write enable, write data and combinational read data. Each pin can be an output or an input. An output pin drives the value held in the data register. An input pin is synchronised into the core clock domain. The synchronised value can be read back, and it feeds an interrupt detector.

Each pin has its own 2-bit sense code that selects low level, high level, rising edge or falling edge. A per-pin any-edge bit overrides that code. When a pin's condition is detected, its sticky status flag is set, and software clears the flag by writing a one to it. A mask register gates the flags onto two interrupt lines: one for the lower half of the pins and one for the upper half.

Top module: `gpio_irq_port`

## Requirements
- R1: Word address selects a register: 0 output data, 1 direction, 2 pad status (read only), 3 sense config for pins 0-15, 4 sense config for pins 16-31, 5 interrupt mask, 6 interrupt status, 7 any-edge select. A write to address 0, 1, 3, 4, 5 or 7 takes effect at the clock edge where wrEn is high. Reading address 0 returns the written data value. Every register is 0 after reset.
- R2: pinOe equals the direction register (1 means output). pinOut carries the data bit for output pins and 0 for input pins.
- R3: Sense code 0 flags while the synchronised pin is low. Code 1 flags while it is high. Code 2 flags a 0-to-1 change. Code 3 flags a 1-to-0 change.
- R4: Pin n (n < 16) takes its code from bits [2n+1:2n] of address 3. Pin n (n >= 16) takes its code from bits [2(n-16)+1:2(n-16)] of address 4.
- R5: A pin whose any-edge bit (address 7) is 1 flags on every change of its synchronised value, whatever its sense code.
- R6: Writing address 6 clears each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. Without a clear, a set status bit stays set.
- R7: A status bit reaches an interrupt output only while its mask bit is 1.
- R8: irqLow is the OR of the masked status of pins 0-15. irqHigh is the OR of the masked status of pins 16-31.
- R9: pinIn passes through two flops. Pad status (address 2) shows a pin value two clock edges after it is sampled. A detection lands in the status register at the edge after that.
- R10: A level-sensed pin sets its flag on every clock while the level is active, so a clear does not stick until the level goes away.
- R11: When a clear and a new detection hit the same status bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word address |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register |
| pinIn | input | 32 | Asynchronous pin input levels |
| pinOut | output | 32 | Pin output levels |
| pinOe | output | 32 | Pin output enables |
| irqLow | output | 1 | Interrupt for pins 0-15 |
| irqHigh | output | 1 | Interrupt for pins 16-31 |

## Verification
The assertions assume that pinIn is held steady around the sampling edge. They also assume that the pad-status relation is only judged once two edges have passed since reset, so values from before reset never matter. The stimulus changes pinIn, addr, wrEn and wrData only on the falling clock edge. Random pin activity flips just a few bits at a time, so edges and levels stay separable. Directed sequences then place a clear write exactly on the edge where a detection lands, and hold a level active across a clear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_EDGE   = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrClear;
    logic    wrEdge;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  output ctrlStrobes_t          strobes
);

  regSel_e sel;

  assign sel = regSel_e'(addr);

  always_comb begin
    strobes         = '0;
    strobes.rdSel   = sel;
    if (wrEn) begin
      unique case (sel)
        REG_DATA:   strobes.wrData  = 1'b1;
        REG_DIR:    strobes.wrDir   = 1'b1;
        REG_PAD:    ;
        REG_CFG_LO: strobes.wrCfgLo = 1'b1;
        REG_CFG_HI: strobes.wrCfgHi = 1'b1;
        REG_MASK:   strobes.wrMask  = 1'b1;
        REG_STAT:   strobes.wrClear = 1'b1;
        REG_EDGE:   strobes.wrEdge  = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_port_pkg::*;
(
  input  logic       syncNow,
  input  logic       syncPrev,
  input  logic [1:0] senseCode,
  input  logic       anyEdge,
  output logic       hit
);

  always_comb begin
    if (anyEdge) begin
      hit = syncNow ^ syncPrev;
    end else begin
      unique case (sense_e'(senseCode))
        SENSE_LOW:  hit = ~syncNow;
        SENSE_HIGH: hit = syncNow;
        SENSE_RISE: hit = syncNow & ~syncPrev;
        SENSE_FALL: hit = ~syncNow & syncPrev;
        default:    hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] statusVec,
  output logic [PIN_COUNT-1:0] maskVec,
  output logic [PIN_COUNT-1:0] padVec,
  output logic                 irqLow,
  output logic                 irqHigh
);

  localparam int HALF = PIN_COUNT / 2;

  logic [PIN_COUNT-1:0] dataQ, dirQ, maskQ, statQ, edgeQ;
  logic [PIN_COUNT-1:0] cfgLoQ, cfgHiQ;
  logic [PIN_COUNT-1:0] syncA, syncB, prevQ;
  logic [PIN_COUNT-1:0] hitVec, clearVec, statNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ  <= '0;
      dirQ   <= '0;
      maskQ  <= '0;
      edgeQ  <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
    end else begin
      if (strobes.wrData)  dataQ  <= wrData;
      if (strobes.wrDir)   dirQ   <= wrData;
      if (strobes.wrMask)  maskQ  <= wrData;
      if (strobes.wrEdge)  edgeQ  <= wrData;
      if (strobes.wrCfgLo) cfgLoQ <= wrData;
      if (strobes.wrCfgHi) cfgHiQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    localparam int SLOT = g % HALF;
    logic [1:0] code;
    if (g < HALF) begin : g_lo
      assign code = cfgLoQ[2*SLOT +: 2];
    end else begin : g_hi
      assign code = cfgHiQ[2*SLOT +: 2];
    end
    gpio_pin_sense i_sense (
      .syncNow  (syncB[g]),
      .syncPrev (prevQ[g]),
      .senseCode(code),
      .anyEdge  (edgeQ[g]),
      .hit      (hitVec[g])
    );
  end

  assign clearVec = strobes.wrClear ? wrData : '0;
  assign statNext = (statQ & ~clearVec) | hitVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statQ <= '0;
    else        statQ <= statNext;
  end

  always_comb begin
    unique case (strobes.rdSel)
      REG_DATA:   rdData = dataQ;
      REG_DIR:    rdData = dirQ;
      REG_PAD:    rdData = syncB;
      REG_CFG_LO: rdData = cfgLoQ;
      REG_CFG_HI: rdData = cfgHiQ;
      REG_MASK:   rdData = maskQ;
      REG_STAT:   rdData = statQ;
      REG_EDGE:   rdData = edgeQ;
      default:    rdData = '0;
    endcase
  end

  assign pinOe     = dirQ;
  assign pinOut    = dataQ & dirQ;
  assign irqLow    = |(statQ[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHigh   = |(statQ[PIN_COUNT-1:HALF] & maskQ[PIN_COUNT-1:HALF]);
  assign statusVec = statQ;
  assign maskVec   = maskQ;
  assign padVec    = syncB;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wrEn,
  input  logic [PIN_COUNT-1:0]  wrData,
  output logic [PIN_COUNT-1:0]  rdData,
  input  logic [PIN_COUNT-1:0]  pinIn,
  output logic [PIN_COUNT-1:0]  pinOut,
  output logic [PIN_COUNT-1:0]  pinOe,
  output logic                  irqLow,
  output logic                  irqHigh
);

  ctrlStrobes_t         strobes;
  logic [PIN_COUNT-1:0] statusVec, maskVec, padVec;

  gpio_port_ctrl i_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobes(strobes)
  );

  gpio_port_datapath #(.PIN_COUNT(PIN_COUNT)) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .statusVec(statusVec),
    .maskVec  (maskVec),
    .padVec   (padVec),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh)
  );

endmodule

// File: rtl/gpio_irq_port_checker.sv
module gpio_irq_port_checker #(
  parameter int PIN_COUNT = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           addr,
  input logic                 wrEn,
  input logic [PIN_COUNT-1:0] wrData,
  input logic [PIN_COUNT-1:0] pinIn,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic [PIN_COUNT-1:0] statusVec,
  input logic [PIN_COUNT-1:0] maskVec,
  input logic [PIN_COUNT-1:0] padVec,
  input logic                 irqLow,
  input logic                 irqHigh
);

  localparam int HALF = PIN_COUNT / 2;

  logic [1:0] sinceReset;
  logic       clearNow;

  assign clearNow = wrEn && (addr == 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  a_r2_out_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pinOut & ~pinOe) == '0);

  a_r6_sticky_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clearNow |=> (($past(statusVec) & ~statusVec) == '0));

  a_r6_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    clearNow |=> (($past(statusVec) & ~$past(wrData) & ~statusVec) == '0));

  a_r7_low_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (maskVec[HALF-1:0] == '0) |-> !irqLow);

  a_r7_high_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (maskVec[PIN_COUNT-1:HALF] == '0) |-> !irqHigh);

  a_r8_low_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irqLow |-> (statusVec[HALF-1:0] != '0));

  a_r8_high_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irqHigh |-> (statusVec[PIN_COUNT-1:HALF] != '0));

  a_r9_pad_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceReset == 2'd3) |-> (padVec == $past(pinIn, 2)));

endmodule

bind gpio_irq_port gpio_irq_port_checker #(.PIN_COUNT(PIN_COUNT)) i_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .pinIn    (pinIn),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .statusVec(statusVec),
  .maskVec  (maskVec),
  .padVec   (padVec),
  .irqLow   (irqLow),
  .irqHigh  (irqHigh)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;

  localparam int N = 32;
  localparam int H = N / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         wrEn = 1'b0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] pinIn = '0;
  logic [N-1:0] rdData, pinOut, pinOe;
  logic         irqLow, irqHigh;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [N-1:0] mData, mDir, mCfgLo, mCfgHi, mMask, mStat, mEdge, mS1, mS2, mPrev;

  always #2 clk = ~clk;

  gpio_irq_port #(.PIN_COUNT(N)) i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  // R3 / R5 reference
  function automatic logic senseHit(logic [1:0] code, logic anyEdge, logic now, logic prev);
    if (anyEdge) return now != prev;
    case (code)
      2'd0: return !now;
      2'd1: return now;
      2'd2: return now && !prev;
      default: return !now && prev;
    endcase
  endfunction

  // R4 code lookup
  function automatic logic [1:0] codeOf(int n);
    if (n < H) return mCfgLo[2*n +: 2];
    return mCfgHi[2*(n-H) +: 2];
  endfunction

  function automatic logic [N-1:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return mData;
      3'd1: return mDir;
      3'd2: return mS2;
      3'd3: return mCfgLo;
      3'd4: return mCfgHi;
      3'd5: return mMask;
      3'd6: return mStat;
      default: return mEdge;
    endcase
  endfunction

  function automatic string readTag(logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R9";
      3'd3: return "R4";
      3'd4: return "R4";
      3'd5: return "R7";
      3'd6: return "R6/R3/R10/R11";
      default: return "R5";
    endcase
  endfunction

  task automatic modelReset();
    mData = '0; mDir = '0; mCfgLo = '0; mCfgHi = '0; mMask = '0;
    mStat = '0; mEdge = '0; mS1 = '0; mS2 = '0; mPrev = '0;
  endtask

  task automatic modelEdge();
    logic [N-1:0] det;
    logic [N-1:0] clr;
    for (int n = 0; n < N; n++) det[n] = senseHit(codeOf(n), mEdge[n], mS2[n], mPrev[n]);
    clr = (wrEn && addr == 3'd6) ? wrData : '0;
    mStat = (mStat & ~clr) | det;   // R11: detection wins
    mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    if (wrEn) begin
      case (addr)
        3'd0: mData = wrData;
        3'd1: mDir = wrData;
        3'd3: mCfgLo = wrData;
        3'd4: mCfgHi = wrData;
        3'd5: mMask = wrData;
        3'd7: mEdge = wrData;
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check(readTag(addr), rdData, expRead(addr));
    check("R2 pinOe", pinOe, mDir);
    check("R2 pinOut", pinOut, mData & mDir);
    check("R8 irqLow", {31'd0, irqLow}, {31'd0, |(mStat[H-1:0] & mMask[H-1:0])});
    check("R8 irqHigh", {31'd0, irqHigh}, {31'd0, |(mStat[N-1:H] & mMask[N-1:H])});
  endtask

  // one cycle: inputs already driven; edge, then check at falling edge
  task automatic tick();
    @(posedge clk);
    if (rst_n) modelEdge(); else modelReset();
    @(negedge clk);
    checkAll();
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    addr = a; wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [2:0] a, int cycles);
    addr = a; wrEn = 1'b0;
    for (int i = 0; i < cycles; i++) tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state of every register
    for (int a = 0; a < 8; a++) begin addr = 3'(a); #0; check("R1 reset", rdData, '0); end
    addr = '0;
    rst_n = 1'b1;
    rd(3'd6, 3);   // R3: code 0 = low level flags all low pins after reset

    // R1 data readback, R2 direction
    wr(3'd0, 32'hA5A5_0F0F);
    wr(3'd1, 32'hFFFF_0000);
    rd(3'd0, 1);
    // R4: pins 0-15 high level (code 1), pins 16-31 rising (code 2)
    wr(3'd3, 32'h5555_5555);
    wr(3'd4, 32'hAAAA_AAAA);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, 3);
    // R7 / R8: unmask all
    wr(3'd5, 32'hFFFF_FFFF);
    // R10: pin 0 held high, clear cannot stick
    pinIn = 32'h0000_0001;
    rd(3'd2, 4);   // R9 pad latency
    wr(3'd6, 32'h0000_0001);
    rd(3'd6, 2);
    pinIn = 32'h0;
    rd(3'd6, 3);
    wr(3'd6, 32'h0000_0001);
    rd(3'd6, 2);
    // R11: rising on pin 20 lands on the same edge as its clear
    pinIn = 32'h0010_0000;
    rd(3'd6, 2);
    wr(3'd6, 32'h0010_0000);
    rd(3'd6, 2);
    wr(3'd6, 32'h0010_0000);
    // R3: falling code on pin 17
    wr(3'd4, 32'hAAAA_AAAE);
    pinIn = 32'h0012_0000;
    rd(3'd6, 4);
    pinIn = 32'h0010_0000;
    rd(3'd6, 4);
    // R5: any-edge on pin 31 (rising code) flags a falling edge too
    wr(3'd7, 32'h8000_0000);
    pinIn = 32'h8010_0000;
    rd(3'd6, 4);
    wr(3'd6, 32'hFFFF_0000);
    pinIn = 32'h0010_0000;
    rd(3'd6, 4);
    // R7: mask the upper half; its flags remain but irqHigh drops
    wr(3'd5, 32'h0000_FFFF);
    rd(3'd6, 2);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] flips;
      flips = '0;
      if ($urandom_range(0, 3) == 0) flips[$urandom_range(0, N-1)] = 1'b1;
      if ($urandom_range(0, 7) == 0) flips[$urandom_range(0, N-1)] = 1'b1;
      pinIn = pinIn ^ flips;
      addr = 3'($urandom_range(0, 7));
      wrEn = ($urandom_range(0, 9) < 3);
      wrData = $urandom();
      tick();
    end
    wrEn = 1'b0;
    rd(3'd6, 2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule